// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmitter from a chain of frame descriptors that a host keeps in shared memory. Each descriptor occupies 32 bytes; the block reads its first three words to learn whether hardware owns it, how many bytes the frame has, where the frame's bytes live and where the following descriptor sits. It then sends the frame out byte by byte on a valid/ready stream and hands the descriptor back to the host by clearing its ownership flag. After that it follows the stored link to the next descriptor. The last link in a ring points back to the first.

The host gives the walker a 32-bit ring start address in two 16-bit writes. It then writes a poll command. The walker keeps walking until it meets a descriptor the host has not handed over. At that point it parks until the next poll. Each frame that is sent sets a sticky finished flag. The host clears that flag by writing a one to it. An interrupt line stays high while any flag is set whose enable bit is also set.

Top module: `txr_dma`

## Requirements
- R1: While reset is held, `tx_valid`, `mem_rd`, `mem_wr` and `irq` are low and `stat_o` is zero.
- R2: A host write with `host_sel`=0 replaces address bits 15:0 of the ring start, and `host_sel`=1 replaces bits 31:16. The walker is idle during these writes. After either write the walker's current descriptor address equals the updated start address.
- R3: A host write with `host_sel`=2 and `host_wdata` bit 0 set starts the idle walker at its current descriptor. Without such a write, no descriptor is fetched and no byte is sent.
- R4: The descriptor word at offset 0 holds the status in bits 15:0 and the length in bits 31:16. Status bit 15 set means hardware owns the descriptor. Offset 4 holds the buffer byte address and offset 8 holds the next-descriptor address. A descriptor with bit 15 clear stops the walk, and the walker writes nothing to it.
- R5: An owned frame is sent as `len` bytes taken from consecutive byte addresses starting at the buffer address. The byte for an address is its lane `addr[1:0]` of the little-endian 32-bit word, so any alignment works. `tx_last` is high on the final byte only.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R7: After the final byte of a descriptor, the walker writes the offset-0 word back with bit 15 cleared and all other status bits and the length unchanged. It then goes on to the next-descriptor address, which allows wrapping from the last entry to the first.
- R8: A descriptor whose length is outside MIN_LEN..MAX_LEN (60..1514 by default) sends no bytes. Its owner bit is still cleared and the walk continues, but the finished flag is not set.
- R9: Each frame that is sent sets `stat_o` bit 4. A host write with `host_sel`=3 clears exactly the status bits written as one. A write of zeros leaves the status unchanged.
- R10: A host write with `host_sel`=4 loads the interrupt enable. `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select: 0 start low, 1 start high, 2 poll, 3 status clear, 4 enable |
| host_wdata | input | 16 | Host write data |
| stat_o | output | 16 | Sticky status, bit 4 = frame finished |
| irq | output | 1 | Interrupt request |
| mem_rd | output | 1 | Word read request; data returns on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench builds the walker with MIN_LEN=4 and MAX_LEN=40. At the default limits a single legal frame would take hundreds of cycles. The smaller limits make both length bounds, a frame below the minimum, a frame above the maximum and a full ring wrap cheap enough to test in one short run. A ready pattern that stalls one cycle in three holds bytes at every phase, and buffers at odd addresses exercise every byte lane.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int ADDR_W = 32;
  localparam int HALF_W = 16;
  localparam int STAT_W = 16;
  localparam int DONE_BIT = 4;
  localparam logic [15:0] OWN_MASK = 16'h8000;
  localparam logic [STAT_W-1:0] STAT_IMPL = STAT_W'(1) << DONE_BIT;

  localparam logic [2:0] SEL_BASE_LO = 3'd0;
  localparam logic [2:0] SEL_BASE_HI = 3'd1;
  localparam logic [2:0] SEL_POLL    = 3'd2;
  localparam logic [2:0] SEL_STAT    = 3'd3;
  localparam logic [2:0] SEL_IEN     = 3'd4;

  typedef enum logic [3:0] {
    W_IDLE, W_HDR, W_HDR_D, W_BUF, W_BUF_D, W_NXT, W_NXT_D,
    W_BRD, W_BRD_D, W_SEND, W_WB
  } walk_st_t;

  function automatic logic len_in_range(input logic [15:0] len, input int lo, input int hi);
    return (int'(len) >= lo) && (int'(len) <= hi);
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] word, input logic [1:0] lane);
    logic [31:0] sh;
    sh = word >> {lane, 3'b000};
    return sh[7:0];
  endfunction

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/txr_hostregs.sv
module txr_hostregs
  import txr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [2:0]           host_sel,
  input  logic [HALF_W-1:0]    host_wdata,
  input  logic                 frame_done,
  output logic                 base_load,
  output logic [ADDR_W-1:0]    base_next,
  output logic                 poll,
  output logic [STAT_W-1:0]    stat_q,
  output logic                 irq
);
  logic [HALF_W-1:0] base_lo_q, base_hi_q;
  logic [STAT_W-1:0] ien_q;
  logic [STAT_W-1:0] clr_bits, set_bits;

  always_comb begin
    base_load = host_we && (host_sel == SEL_BASE_LO || host_sel == SEL_BASE_HI);
    base_next = (host_sel == SEL_BASE_LO) ? {base_hi_q, host_wdata} : {host_wdata, base_lo_q};
    poll      = host_we && (host_sel == SEL_POLL) && host_wdata[0];
    clr_bits  = (host_we && host_sel == SEL_STAT) ? host_wdata : '0;
    set_bits  = frame_done ? STAT_IMPL : '0;
    irq       = |(stat_q & ien_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      ien_q     <= '0;
      stat_q    <= '0;
    end else begin
      if (base_load) begin
        base_lo_q <= base_next[HALF_W-1:0];
        base_hi_q <= base_next[ADDR_W-1:HALF_W];
      end
      if (host_we && host_sel == SEL_IEN) ien_q <= host_wdata;
      stat_q <= ((stat_q & ~clr_bits) | set_bits) & STAT_IMPL;
    end
  end
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_next,
  input  logic              poll,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              frame_done,
  output logic              desc_retire
);
  walk_st_t st;
  logic [ADDR_W-1:0] cur_ptr, nxt_ptr, buf_ptr, byte_addr;
  logic [15:0] len_q, dstat_q, idx;
  logic [7:0]  byte_q;
  logic        last_idx;

  always_comb begin
    byte_addr   = buf_ptr + {16'h0, idx};
    last_idx    = (idx == len_q - 16'd1);
    mem_rd      = (st == W_HDR) || (st == W_BUF) || (st == W_NXT) || (st == W_BRD);
    mem_wr      = (st == W_WB);
    mem_wdata   = {len_q, dstat_q & ~OWN_MASK};
    tx_valid    = (st == W_SEND);
    tx_data     = byte_q;
    tx_last     = tx_valid && last_idx;
    desc_retire = (st == W_WB);
    frame_done  = desc_retire && len_in_range(len_q, MIN_LEN, MAX_LEN);
    case (st)
      W_BUF:   mem_addr = cur_ptr + 32'd4;
      W_NXT:   mem_addr = cur_ptr + 32'd8;
      W_BRD:   mem_addr = word_align(byte_addr);
      default: mem_addr = cur_ptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      cur_ptr <= '0;
      nxt_ptr <= '0;
      buf_ptr <= '0;
      len_q   <= '0;
      dstat_q <= '0;
      idx     <= '0;
      byte_q  <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (base_load) cur_ptr <= base_next;
          else if (poll) st <= W_HDR;
        end
        W_HDR: st <= W_HDR_D;
        W_HDR_D: begin
          dstat_q <= mem_rdata[15:0];
          len_q   <= mem_rdata[31:16];
          st      <= (mem_rdata[15:0] & OWN_MASK) != 16'h0 ? W_BUF : W_IDLE;
        end
        W_BUF: st <= W_BUF_D;
        W_BUF_D: begin
          buf_ptr <= mem_rdata;
          st      <= W_NXT;
        end
        W_NXT: st <= W_NXT_D;
        W_NXT_D: begin
          nxt_ptr <= mem_rdata;
          idx     <= '0;
          st      <= len_in_range(len_q, MIN_LEN, MAX_LEN) ? W_BRD : W_WB;
        end
        W_BRD: st <= W_BRD_D;
        W_BRD_D: begin
          byte_q <= lane_pick(mem_rdata, byte_addr[1:0]);
          st     <= W_SEND;
        end
        W_SEND: begin
          if (tx_ready) begin
            if (last_idx) st <= W_WB;
            else begin
              idx <= idx + 16'd1;
              st  <= W_BRD;
            end
          end
        end
        W_WB: begin
          cur_ptr <= nxt_ptr;
          st      <= W_HDR;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_dma.sv
module txr_dma
  import txr_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] stat_o,
  output logic        irq,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic              base_load, poll, frame_done, desc_retire;
  logic [ADDR_W-1:0] base_next;

  txr_hostregs u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .frame_done(frame_done), .base_load(base_load),
    .base_next(base_next), .poll(poll), .stat_q(stat_o), .irq(irq)
  );

  txr_walker #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_walk (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_next(base_next),
    .poll(poll), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .frame_done(frame_done), .desc_retire(desc_retire)
  );
endmodule

// File: rtl/txr_dma_chk.sv
module txr_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [2:0]  host_sel,
  input logic [15:0] host_wdata,
  input logic [15:0] stat_o,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_wdata,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        tx_ready,
  input logic        frame_done,
  input logic        desc_retire
);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r5_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r7_owner_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_wdata[15]);

  a_r7_retire_writes: assert property (@(posedge clk) disable iff (!rst_n)
    desc_retire |-> mem_wr && !mem_rd && !tx_valid);

  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> stat_o[4]);

  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == 3'd3 && host_wdata[4] && !frame_done |=> !stat_o[4]);

  a_r8_short_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    desc_retire && !frame_done |-> !$past(tx_valid));
endmodule

bind txr_dma txr_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .stat_o(stat_o), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_ready(tx_ready), .frame_done(frame_done),
  .desc_retire(desc_retire)
);

// File: tb/txr_dma_test.sv
`timescale 1ns/1ps
module txr_dma_test;
  localparam int LO = 4;
  localparam int HI = 40;
  localparam int D0 = 'h100, D1 = 'h120, D2 = 'h140;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_sel = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] stat_o;
  logic irq, mem_rd, mem_wr, tx_valid, tx_last;
  logic tx_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [7:0] tx_data;

  logic [7:0] mem [0:1023];
  logic [8:0] sb_q[$];
  int n_chk = 0, n_bad = 0, rdy_cnt = 0;
  bit finished = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data;
  logic prev_last;

  always #2 clk = ~clk;

  txr_dma #(.MIN_LEN(LO), .MAX_LEN(HI)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .stat_o(stat_o), .irq(irq), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );

  function automatic logic [31:0] rd32(input int a);
    int b;
    b = a & 'h3FC;
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  task automatic wr32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[(a & 'h3FC) + i] = v[8*i +: 8];
  endtask

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= rd32(int'(mem_addr[9:0]));
    if (mem_wr) wr32(int'(mem_addr[9:0]), mem_wdata);
  end

  always @(posedge clk) begin
    #1;
    rdy_cnt = rdy_cnt + 1;
    tx_ready = (rdy_cnt % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted byte
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(tx_valid && tx_data == prev_data && tx_last == prev_last, "R6 hold",
            {22'h0, tx_valid, tx_last, tx_data}, {22'h0, 1'b1, prev_last, prev_data});
      if (tx_valid && tx_ready) begin
        if (sb_q.size() == 0) chk(1'b0, "R3 unexpected byte", {24'h0, tx_data}, 32'h0);
        else begin
          logic [8:0] e;
          e = sb_q.pop_front();
          chk({tx_last, tx_data} == e, "R5 byte/last", {23'h0, tx_last, tx_data}, {23'h0, e});
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
    end
  end

  task automatic host_wr(input logic [2:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic set_desc(input int a, input logic [15:0] st, input logic [15:0] len,
                          input int bufp, input int nxt);
    wr32(a, {len, st});
    wr32(a + 4, 32'(bufp));
    wr32(a + 8, 32'(nxt));
  endtask

  task automatic expect_frame(input int bufp, input int n);
    for (int i = 0; i < n; i++) sb_q.push_back({i == n - 1, mem[bufp + i]});
  endtask

  task automatic settle();
    repeat (400) @(posedge clk);
    #1;
    chk(sb_q.size() == 0, "R5 frame fully sent", sb_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    set_desc(D0, 16'h8041, 16'd5, 'h200, D1);
    set_desc(D1, 16'h8102, 16'd7, 'h281, D2);
    set_desc(D2, 16'h0000, 16'd9, 'h300, D0);
    repeat (3) @(posedge clk);
    #1;
    chk(!tx_valid && !mem_rd && !mem_wr, "R1 outputs quiet", {29'h0, tx_valid, mem_rd, mem_wr}, 0);
    chk(stat_o == 0 && !irq, "R1 status clear", {15'h0, irq, stat_o}, 0);
    rst_n = 1'b1;

    // R3: owned descriptors but no poll yet
    host_wr(3'd4, 16'h0010);
    host_wr(3'd0, 16'(D0));
    host_wr(3'd1, 16'h0000);
    repeat (50) @(posedge clk);
    #1;
    chk(rd32(D0) == 32'h00058041, "R3 no fetch without poll", rd32(D0), 32'h00058041);

    // R5/R7: two frames, one at an odd buffer address, stop at unowned D2
    expect_frame('h200, 5);
    expect_frame('h281, 7);
    host_wr(3'd2, 16'h0001);
    settle();
    chk(rd32(D0) == 32'h00050041, "R7 D0 handed back", rd32(D0), 32'h00050041);
    chk(rd32(D1) == 32'h00070102, "R7 D1 handed back", rd32(D1), 32'h00070102);
    chk(rd32(D2) == 32'h00090000, "R4 unowned D2 untouched", rd32(D2), 32'h00090000);
    chk(stat_o == 16'h0010, "R9 finished set", stat_o, 16'h0010);
    chk(irq, "R10 irq with enable", irq, 1);
    host_wr(3'd4, 16'h0000);
    chk(!irq, "R10 irq masked", irq, 0);
    host_wr(3'd4, 16'h0010);
    host_wr(3'd3, 16'h0000);
    chk(stat_o == 16'h0010, "R9 zero write keeps", stat_o, 16'h0010);
    host_wr(3'd3, 16'h0010);
    chk(stat_o == 16'h0000 && !irq, "R9 W1C clears", {15'h0, irq, stat_o}, 0);

    // R8: over-max and under-min lengths skipped, ring wraps D2 -> D0 -> D1
    set_desc(D2, 16'h8005, 16'd50, 'h300, D0);
    set_desc(D0, 16'h8006, 16'd3, 'h200, D1);
    host_wr(3'd2, 16'h0001);
    settle();
    chk(rd32(D2) == 32'h00320005, "R8 over-max owner cleared", rd32(D2), 32'h00320005);
    chk(rd32(D0) == 32'h00030006, "R8 under-min owner cleared", rd32(D0), 32'h00030006);
    chk(stat_o == 16'h0000, "R8 no finished flag", stat_o, 0);

    // minimum length frame at D1 (walker parked there)
    set_desc(D1, 16'h8000, 16'(LO), 'h283, D2);
    expect_frame('h283, LO);
    host_wr(3'd2, 16'h0001);
    settle();
    chk(rd32(D1) == {16'(LO), 16'h0000}, "R7 min frame handed back", rd32(D1), {16'(LO), 16'h0000});
    chk(stat_o == 16'h0010, "R9 set by min frame", stat_o, 16'h0010);

    // R3: poll write with bit0 clear does not start
    set_desc(D2, 16'h8000, 16'd6, 'h302, D0);
    host_wr(3'd2, 16'h0002);
    repeat (60) @(posedge clk);
    #1;
    chk(rd32(D2) == 32'h00068000, "R3 poll bit0 clear ignored", rd32(D2), 32'h00068000);
    expect_frame('h302, 6);
    host_wr(3'd2, 16'h0001);
    settle();
    chk(rd32(D2) == 32'h00060000, "R7 D2 handed back", rd32(D2), 32'h00060000);

    // R2: new start address, maximum length frame
    set_desc(D1, 16'h8000, 16'(HI), 'h200, D2);
    host_wr(3'd0, 16'(D1));
    host_wr(3'd1, 16'h0000);
    expect_frame('h200, HI);
    host_wr(3'd2, 16'h0001);
    settle();
    chk(rd32(D1) == {16'(HI), 16'h0000}, "R2 restart at new start", rd32(D1), {16'(HI), 16'h0000});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule